// File: doc/BRIEF.md
# Video Line Assembler with Ping-Pong Line Memories

This block sits after a pixel deserializer in the processing clock domain. It takes a stream of 8-bit grey-scale pixel words. Each word carries a frame-valid flag and a line-valid flag, and a valid strobe marks each word; the strobe is typically high about once every four cycles. The block watches how the two flags change from one valid word to the next. It writes the pixels of the current line into one of two line memories, and it closes the line when the flags say the line has ended.

When a line closes, the two memories change roles. The filled memory is offered to a downstream reader, together with the line's position in the frame, its pixel count and a start-of-frame mark. Meanwhile the next line fills the other memory. The reader fetches pixels through a one-cycle-latency request/address/data port and then acknowledges the line. Because two memories alternate, a reader with unknown latency never sees its line overwritten.

If a further line completes before the reader has acknowledged, that line is discarded and a sticky overrun flag is raised. Lines longer than the memory depth are cut to the memory depth, and a sticky length-error flag is raised.

Top module: `line_assembler`

## Requirements
- R1: A pixel is written only from a word whose valid strobe is high and whose frame-valid and line-valid flags are both high. Words with the strobe low, and valid words with either flag low, store nothing and do not change any output.
- R2: A line closes on the first valid word whose flags are not both high, directly after a valid word whose flags were both high. On the clock edge that samples that word, `line_ready` rises. `line_len` then equals the number of pixels stored, and pixel k of the line is read at address k.
- R3: A valid word with frame-valid high, after a valid word with frame-valid low, resets the line index to 0. The first line closed after that word carries `line_sof`=1 and index 0. Later lines carry `line_sof`=0, and the index goes up by one for every closed line, including dropped ones.
- R4: `line_ready`, `line_index`, `line_len`, `line_sof` and the shown memory stay unchanged until `line_ack` is sampled high while `line_ready` is high. `line_ready` falls on that edge, unless a new line closes on the same edge.
- R5: While a delivered line is shown to the reader, the following line is written into the other memory, so the shown pixels stay intact while the next line fills.
- R6: `rd_req` sampled high with `rd_addr` returns the shown memory's pixel on `rd_data`, with `rd_valid` high, one edge later. `rd_valid` is low on the edge after a cycle without a request.
- R7: A line that closes while `line_ready` is high and `line_ack` is low is discarded. `overrun` goes high on that edge and stays high until reset, and the shown line and its descriptor are left unchanged.
- R8: At most LINE_MAX (752) pixels are stored per line. Further pixels are discarded, `line_len` reports 752, and `too_long` goes high on the edge that samples the first extra pixel and stays high until reset.
- R9: While `rst_n` is low, `line_ready`, `rd_valid`, `overrun` and `too_long` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_pixel | input | 8 | Grey-scale pixel value |
| in_fv | input | 1 | Frame-valid flag of the word |
| in_lv | input | 1 | Line-valid flag of the word |
| rd_req | input | 1 | Read request to the shown memory |
| rd_addr | input | 10 | Pixel address within the shown line |
| rd_data | output | 8 | Pixel returned one cycle after the request |
| rd_valid | output | 1 | High when `rd_data` answers a request |
| line_ready | output | 1 | A completed line is available |
| line_index | output | 9 | Line position within the frame |
| line_len | output | 10 | Number of stored pixels in the shown line |
| line_sof | output | 1 | Shown line is the first of its frame |
| line_ack | input | 1 | Reader is finished with the shown line |
| overrun | output | 1 | Sticky: a line was dropped |
| too_long | output | 1 | Sticky: a line exceeded LINE_MAX pixels |

## Verification
Every registered result in this block follows its cause by exactly one clock edge. `line_ready` and its descriptor change on the edge that samples the closing word. `rd_data` and `rd_valid` change on the edge that samples the request. `line_ready` falls on the edge that samples the acknowledge, and `overrun` and `too_long` rise on the edge that samples the dropped line's close or the first surplus pixel.

The bench drives every input on the falling edge. It samples outputs at the next falling edge, half a cycle after the edge that updates them, so each comparison falls in the first cycle where the new value is defined. Word spacing and gaps between lines are chosen so that a new line's close can never coincide with an acknowledge or a pending read, except in the deliberate overrun scene.

// File: rtl/line_assembler_pkg.sv
package line_assembler_pkg;

  localparam int NUM_BANKS = 2;

  // A word contributes a pixel only when both flags are high.
  function automatic logic word_active(input logic fv, input logic lv);
    return fv & lv;
  endfunction

  // Pixel counter step that saturates at the memory depth.
  function automatic int sat_next(input int cnt, input int lim);
    return (cnt < lim) ? cnt + 1 : cnt;
  endfunction

  // True when a store request finds the line memory already full.
  function automatic logic is_surplus(input int cnt, input int lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/line_assembler_flags.sv
module line_assembler_flags
  import line_assembler_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_fv,
  input  logic in_lv,
  output logic store,
  output logic close,
  output logic fv_rise
);

  logic prev_fv;
  logic prev_act;
  logic cur_act;

  assign cur_act = word_active(in_fv, in_lv);
  assign store   = in_valid & cur_act;
  assign close   = in_valid & prev_act & ~cur_act;
  assign fv_rise = in_valid & in_fv & ~prev_fv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_fv  <= 1'b0;
      prev_act <= 1'b0;
    end else if (in_valid) begin
      prev_fv  <= in_fv;
      prev_act <= cur_act;
    end
  end

  // R2: a line can only be closed by a word that does not itself store a pixel
  assert_close_not_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    close |-> !store);

  // R3: a frame start is never also a line close
  assert_rise_not_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fv_rise |-> !close);

endmodule

// File: rtl/line_assembler_wrctl.sv
module line_assembler_wrctl
  import line_assembler_pkg::*;
#(
  parameter int LINE_MAX = 752,
  parameter int AW = $clog2(LINE_MAX),
  parameter int CW = $clog2(LINE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store,
  input  logic          close,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [CW-1:0] pix_cnt,
  output logic          surplus,
  output logic          too_long
);

  logic full;

  assign full    = is_surplus(int'(pix_cnt), LINE_MAX);
  assign we      = store & ~full;
  assign surplus = store & full;
  assign waddr   = pix_cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      too_long <= 1'b0;
    end else begin
      if (close) begin
        pix_cnt <= '0;
      end else if (store) begin
        pix_cnt <= CW'(sat_next(int'(pix_cnt), LINE_MAX));
      end
      if (surplus) begin
        too_long <= 1'b1;
      end
    end
  end

  // R8: the counter never passes the memory depth
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pix_cnt) <= LINE_MAX);

  // R8: a surplus pixel raises the length error on the next edge
  assert_trunc_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    surplus |=> too_long);

  // R8: the length error is sticky
  assert_trunc_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    too_long |=> too_long);

  // R2: each line starts counting from zero after a close
  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> pix_cnt == '0);

endmodule

// File: rtl/line_assembler_mem.sv
module line_assembler_mem
  import line_assembler_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LINE_MAX = 752,
  parameter int AW = $clog2(LINE_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             wbank,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             rd_req,
  input  logic             rd_bank,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_data,
  output logic             rd_valid
);

  logic [PIX_W-1:0] bank_rd [NUM_BANKS];
  logic             sel_q;
  logic             addr_ok;

  assign addr_ok = int'(rd_addr) < LINE_MAX;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [PIX_W-1:0] cells [LINE_MAX];
    logic [PIX_W-1:0] rdq;

    always_ff @(posedge clk) begin
      if (we && (wbank == 1'(g))) begin
        cells[waddr] <= wdata;
      end
      if (rd_req && addr_ok) begin
        rdq <= cells[rd_addr];
      end
    end

    assign bank_rd[g] = rdq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      sel_q    <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        sel_q <= rd_bank;
      end
    end
  end

  assign rd_data = bank_rd[sel_q];

  // R6: the returned data always comes from the bank that was shown at request time
  assert_read_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> sel_q == $past(rd_bank));

endmodule

// File: rtl/line_assembler_handoff.sv
module line_assembler_handoff
  import line_assembler_pkg::*;
#(
  parameter int LINES = 480,
  parameter int LINE_MAX = 752,
  parameter int CW = $clog2(LINE_MAX + 1),
  parameter int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          close,
  input  logic          fv_rise,
  input  logic [CW-1:0] pix_cnt,
  input  logic          line_ack,
  output logic          wr_bank,
  output logic          rd_bank,
  output logic          line_ready,
  output logic [LW-1:0] line_index,
  output logic [CW-1:0] line_len,
  output logic          line_sof,
  output logic          overrun,
  output logic          drop
);

  logic          busy;
  logic          deliver;
  logic [LW-1:0] line_cnt;
  logic          sof_pend;

  assign busy    = line_ready & ~line_ack;
  assign deliver = close & ~busy;
  assign drop    = close & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      sof_pend <= 1'b0;
    end else if (fv_rise) begin
      line_cnt <= '0;
      sof_pend <= 1'b1;
    end else if (close) begin
      line_cnt <= line_cnt + 1'b1;
      sof_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank    <= 1'b0;
      rd_bank    <= 1'b1;
      line_ready <= 1'b0;
      line_index <= '0;
      line_len   <= '0;
      line_sof   <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (deliver) begin
        line_ready <= 1'b1;
        line_index <= line_cnt;
        line_len   <= pix_cnt;
        line_sof   <= sof_pend;
        rd_bank    <= wr_bank;
        wr_bank    <= ~wr_bank;
      end else if (line_ready && line_ack) begin
        line_ready <= 1'b0;
      end
      if (drop) begin
        overrun <= 1'b1;
      end
    end
  end

  // R4: an unacknowledged line and its descriptor are held
  assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ready && !line_ack) |=> (line_ready && $stable(line_index) &&
                                   $stable(line_len) && $stable(line_sof) && $stable(rd_bank)));

  // R4: an acknowledge without a new line clears the ready flag
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ready && line_ack && !close) |=> !line_ready);

  // R7: a line completed against a busy reader raises overrun
  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);

  // R7: overrun is sticky
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R3: a frame start returns the line counter to zero
  assert_frame_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fv_rise |=> line_cnt == '0);

  // R5: the two banks never hold the same role
  assert_banks_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bank != rd_bank);

endmodule

// File: rtl/line_assembler.sv
module line_assembler
  import line_assembler_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LINE_MAX = 752,
  parameter int LINES = 480,
  localparam int AW = $clog2(LINE_MAX),
  localparam int CW = $clog2(LINE_MAX + 1),
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic             in_fv,
  input  logic             in_lv,
  input  logic             rd_req,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             line_ready,
  output logic [LW-1:0]    line_index,
  output logic [CW-1:0]    line_len,
  output logic             line_sof,
  input  logic             line_ack,
  output logic             overrun,
  output logic             too_long
);

  // Internal events brought out as named wires
  logic          ev_store;
  logic          ev_close;
  logic          ev_fv_rise;
  logic          ev_surplus;
  logic          ev_drop;
  logic          we;
  logic [AW-1:0] waddr;
  logic [CW-1:0] pix_cnt;
  logic          wr_bank;
  logic          rd_bank;

  line_assembler_flags i_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_fv    (in_fv),
    .in_lv    (in_lv),
    .store    (ev_store),
    .close    (ev_close),
    .fv_rise  (ev_fv_rise)
  );

  line_assembler_wrctl #(
    .LINE_MAX (LINE_MAX),
    .AW       (AW),
    .CW       (CW)
  ) i_wrctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .store    (ev_store),
    .close    (ev_close),
    .we       (we),
    .waddr    (waddr),
    .pix_cnt  (pix_cnt),
    .surplus  (ev_surplus),
    .too_long (too_long)
  );

  line_assembler_handoff #(
    .LINES    (LINES),
    .LINE_MAX (LINE_MAX),
    .CW       (CW),
    .LW       (LW)
  ) i_handoff (
    .clk        (clk),
    .rst_n      (rst_n),
    .close      (ev_close),
    .fv_rise    (ev_fv_rise),
    .pix_cnt    (pix_cnt),
    .line_ack   (line_ack),
    .wr_bank    (wr_bank),
    .rd_bank    (rd_bank),
    .line_ready (line_ready),
    .line_index (line_index),
    .line_len   (line_len),
    .line_sof   (line_sof),
    .overrun    (overrun),
    .drop       (ev_drop)
  );

  line_assembler_mem #(
    .PIX_W    (PIX_W),
    .LINE_MAX (LINE_MAX),
    .AW       (AW)
  ) i_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .wbank    (wr_bank),
    .waddr    (waddr),
    .wdata    (in_pixel),
    .rd_req   (rd_req),
    .rd_bank  (rd_bank),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // R5: a pixel write never lands in the bank shown to the reader
  assert_no_write_shown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && line_ready) |-> (wr_bank != rd_bank));

  // R1: storage happens only on active, strobed words
  assert_store_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (in_valid && in_fv && in_lv));

  // R7: a dropped line leaves the shown bank and descriptor in place
  assert_drop_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> ($stable(rd_bank) && $stable(line_len) && line_ready));

  // R8: a surplus pixel is never written
  assert_surplus_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_surplus |-> !we);

endmodule

// File: tb/test_line_assembler.sv
module test_line_assembler;

  localparam int LINE_MAX = 752;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_pixel;
  logic       in_fv;
  logic       in_lv;
  logic       rd_req;
  logic [9:0] rd_addr;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       line_ready;
  logic [8:0] line_index;
  logic [9:0] line_len;
  logic       line_sof;
  logic       line_ack;
  logic       overrun;
  logic       too_long;

  always #4 clk = ~clk;

  line_assembler i_line_assembler (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_pixel (in_pixel),
    .in_fv (in_fv), .in_lv (in_lv), .rd_req (rd_req), .rd_addr (rd_addr),
    .rd_data (rd_data), .rd_valid (rd_valid), .line_ready (line_ready),
    .line_index (line_index), .line_len (line_len), .line_sof (line_sof),
    .line_ack (line_ack), .overrun (overrun), .too_long (too_long)
  );

  typedef struct {
    int idx;
    int len;
    bit sof;
    int seed;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   hold = 1'b0;
  bit   busy = 1'b0;
  bit   finished = 1'b0;
  bit   started = 1'b0;
  int   exp_idx = 0;
  bit   sof_next = 1'b0;

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 7 + k * 3 + (k >> 4)) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One word every four cycles; the idle cycles carry random garbage (R1).
  task automatic word(input bit fv, input bit lv, input logic [7:0] p);
    @(negedge clk);
    in_valid = 1'b1; in_fv = fv; in_lv = lv; in_pixel = p;
    repeat (3) begin
      @(negedge clk);
      in_valid = 1'b0; in_fv = 1'($urandom); in_lv = 1'($urandom); in_pixel = 8'($urandom);
    end
  endtask

  task automatic frame_start();
    repeat (3) word(1'b0, 1'b1, 8'($urandom));   // frame-valid low: ignored (R1)
    word(1'b0, 1'b0, 8'($urandom));
    exp_idx  = 0;
    sof_next = 1'b1;
  endtask

  task automatic frame_end();
    repeat (5) word(1'b0, 1'b0, 8'($urandom));
  endtask

  task automatic send_line(input int n, input int seed, input bit keep);
    exp_t e;
    for (int k = 0; k < n; k++) word(1'b1, 1'b1, pat(seed, k));
    if (keep) begin
      e.idx = exp_idx; e.len = (n > LINE_MAX) ? LINE_MAX : n;
      e.sof = sof_next; e.seed = seed;
      q.push_back(e);
    end
    exp_idx++;
    sof_next = 1'b0;
    repeat (15) word(1'b1, 1'b0, 8'($urandom));     // close word plus gap with line-valid low
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || q.size() != 0 || line_ready);
  endtask

  // Scoreboard monitor / reader
  initial begin
    exp_t e;
    int bad;
    int bad_act;
    int bad_exp;
    rd_req = 1'b0; rd_addr = '0; line_ack = 1'b0;
    wait (started);
    forever begin
      @(negedge clk);
      if (line_ready && !hold && !finished) begin
        busy = 1'b1;
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected line index", int'(line_index), -1);
        end else begin
          e = q.pop_front();
          check(int'(line_index) == e.idx, "R3", "line_index", int'(line_index), e.idx);
          check(line_sof == e.sof, "R3", "line_sof", int'(line_sof), int'(e.sof));
          check(int'(line_len) == e.len, "R1 R2 R8", "line_len", int'(line_len), e.len);
          repeat ($urandom_range(0, 20)) @(negedge clk);
          check(line_ready == 1'b1, "R4", "line_ready held before ack", int'(line_ready), 1);
          bad = 0; bad_act = 0; bad_exp = 0;
          for (int k = 0; k < e.len; k++) begin
            rd_req = 1'b1; rd_addr = 10'(k);
            @(negedge clk);
            if (!rd_valid || rd_data !== pat(e.seed, k)) begin
              if (bad == 0) begin bad_act = int'(rd_data); bad_exp = int'(pat(e.seed, k)); end
              bad++;
            end
          end
          rd_req = 1'b0;
          check(bad == 0, "R5 R6", "first bad pixel", bad_act, bad_exp);
          line_ack = 1'b1;
          @(negedge clk);
          line_ack = 1'b0;
          check(line_ready == 1'b0, "R4", "line_ready after ack", int'(line_ready), 0);
          check(rd_valid == 1'b0, "R6", "rd_valid without request", int'(rd_valid), 0);
        end
        busy = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_fv = 1'b0; in_lv = 1'b0; in_pixel = '0;
    repeat (5) @(negedge clk);
    check(line_ready == 1'b0, "R9", "line_ready in reset", int'(line_ready), 0);
    check(rd_valid == 1'b0, "R9", "rd_valid in reset", int'(rd_valid), 0);
    check(overrun == 1'b0, "R9", "overrun in reset", int'(overrun), 0);
    check(too_long == 1'b0, "R9", "too_long in reset", int'(too_long), 0);
    rst_n = 1'b1;
    started = 1'b1;

    // Frame 1: mixed lengths, including exactly full depth
    frame_start();
    send_line(16, 3, 1'b1);
    send_line(40, 11, 1'b1);
    send_line(752, 23, 1'b1);
    frame_end();
    wait_idle();

    // Frame 2: index restarts, tiny lines
    frame_start();
    send_line(5, 41, 1'b1);
    send_line(1, 57, 1'b1);
    send_line(33, 60, 1'b1);
    frame_end();
    wait_idle();
    check(overrun == 1'b0, "R7", "no overrun with prompt reader", int'(overrun), 0);
    check(too_long == 1'b0, "R8", "no length error at full depth", int'(too_long), 0);

    // Frame 3: reader stalled, second line must be dropped
    hold = 1'b1;
    frame_start();
    send_line(10, 77, 1'b1);
    send_line(12, 91, 1'b0);
    check(overrun == 1'b1, "R7", "overrun after drop", int'(overrun), 1);
    check(line_ready == 1'b1, "R7", "shown line kept", int'(line_ready), 1);
    check(int'(line_len) == 10, "R7", "shown length kept", int'(line_len), 10);
    check(int'(line_index) == 0, "R7", "shown index kept", int'(line_index), 0);
    hold = 1'b0;
    wait_idle();
    send_line(20, 101, 1'b1);
    frame_end();
    wait_idle();
    check(overrun == 1'b1, "R7", "overrun sticky", int'(overrun), 1);

    // Frame 4: over-long line truncated
    frame_start();
    send_line(760, 130, 1'b1);
    wait_idle();
    check(too_long == 1'b1, "R8", "too_long after long line", int'(too_long), 1);
    send_line(8, 140, 1'b1);
    frame_end();
    wait_idle();
    check(too_long == 1'b1, "R8", "too_long sticky", int'(too_long), 1);
    check(q.size() == 0, "R2", "lines left undelivered", q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule